// File: doc/BRIEF.md
# Destination Address Hash Filter

This block decides whether the destination MAC address of a received frame is one the station accepts. On a lookup strobe it folds the 48-bit address into an 11-bit home index, then walks a 2048-slot table held in an external memory, one 64-bit slot per probe. The walk starts at the home index and moves up one slot at a time, wrapping from the top slot to slot 0. It stops on the first empty slot, on the first slot holding the same address, or when the hop budget runs out.

Each slot packs the address into a fixed bit layout. The low word also carries three flag bits: occupied, skip and discard. When a matching slot is found, the block reports a hit together with that slot's skip and discard flags. Software fills the table through its own path, and the block only reads it.

The result appears with a one-cycle `done` pulse. The hit and flag outputs hold their value until the next result.

Top module: `macfilt_top`

## Requirements
- R1: After reset, `done`, `hit`, `skipFlag`, `discardFlag` and `memRdEn` are all 0.
- R2: The home index is computed as follows. Name the bytes B0 = `macAddr[47:40]` through B5 = `macAddr[7:0]`. Let T be {B2,B3,B4,B5} with every byte bit-reversed, and let t be bit 0 of bit-reversed B1. The index is {T[3:2], F}, where F = {T[14:8],T[1:0]} ^ T[23:15] ^ {t,T[31:24]}. The first read of a lookup goes to this index.
- R3: In the low word (`memRdData[31:0]`), bit 0 is occupied, bit 1 is skip and bit 2 is discard. The rest of the low word holds B0 low nibble at 6:3, B0 high nibble at 10:7, B1 nibbles at 14:11 and 18:15, B2 nibbles at 22:19 and 26:23, B3 low nibble at 30:27 and B3 bit 4 at 31. The high word (`memRdData[63:32]`) holds B3 bits 7:5 at 2:0, B4 nibbles at 6:3 and 10:7, B5 nibbles at 14:11 and 18:15, and zeros above. A slot matches when low-word bits 31:3 and the whole high word equal the encoding of the address. Low-word bits 2:0 take no part in the comparison.
- R4: Successive probes of one lookup read consecutive slots, and slot 2047 is followed by slot 0.
- R5: Reaching a slot whose occupied bit is 0 ends the lookup as a miss.
- R6: A lookup never issues more than HOPS reads (default 12). If HOPS slots are read without a match, the result is a miss, even when the address sits in the next slot.
- R7: On a hit, `skipFlag` and `discardFlag` equal bits 1 and 2 of the matching slot. On a miss both are 0.
- R8: Each probe takes two cycles: `memRdEn` is high for one cycle and the data is used in the next. `done` rises 2N cycles after the strobe is sampled, where N is the number of probes, and stays high for exactly one cycle.
- R9: A strobe that arrives while a lookup is in progress is ignored. It neither changes the result nor adds reads or `done` pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| lookupStb | input | 1 | Starts a lookup when the block is idle |
| macAddr | input | 48 | Destination address, first byte in bits 47:40 |
| memRdEn | output | 1 | Table read request |
| memAddr | output | 11 | Table slot being read |
| memRdData | input | 64 | Slot contents one cycle after the request: high word 63:32, low word 31:0 |
| done | output | 1 | One-cycle result pulse |
| hit | output | 1 | Address found in the table |
| skipFlag | output | 1 | Skip bit of the matching slot |
| discardFlag | output | 1 | Discard bit of the matching slot |

## Verification
The bench loads a reference table and applies the following cases:
- An empty table, which shows the home index and the stop on an empty slot.
- A target in its home slot, and a target two slots past colliding entries, which separate a correct probe order from a fixed or wrong index.
- An address whose home index is 2047, which exercises the wraparound.
- A run of exactly HOPS colliding slots with the target just beyond it, which separates an off-by-one hop budget from a correct one.
- Near-miss slots that differ from the target in a single high-word or low-word address bit, and a matching slot with all three flag bits set. Together these tell an exact tag compare apart from one that drops bits or includes the flag field.
- A second strobe injected mid-walk, which shows that a busy lookup cannot be restarted.

// File: rtl/macfilt_pkg.sv
package macfilt_pkg;
  localparam int IDX_W = 11;
  localparam int ADDR_W = 48;
  localparam int WORD_W = 32;
  localparam int TAG_LO_W = WORD_W - 3;

  typedef logic [IDX_W-1:0] idxT;

  typedef struct packed {
    logic [WORD_W-1:0] hi;
    logic [WORD_W-1:0] lo;
  } entryT;

  typedef struct packed {
    logic [WORD_W-1:0]   hi;
    logic [TAG_LO_W-1:0] loTag;
  } keyT;

  typedef struct packed {
    logic load;
    logic advance;
    logic capture;
  } ctlT;

  typedef struct packed {
    logic entryValid;
    logic keyMatch;
    logic lastHop;
  } stsT;

  typedef enum logic [1:0] {ST_IDLE, ST_READ, ST_EVAL} stT;

  // Slot tag layout: low word 31:3 holds {B3[4:0],B2,B1,B0}; high word
  // holds {B5,B4,B3[7:5]} in its low 19 bits.
  function automatic keyT keyOf(input logic [ADDR_W-1:0] a);
    keyT k;
    k.loTag = {a[20:16], a[31:24], a[39:32], a[47:40]};
    k.hi    = {13'd0, a[7:0], a[15:8], a[23:21]};
    return k;
  endfunction
endpackage

// File: rtl/macfilt_hash.sv
module macfilt_hash
  import macfilt_pkg::*;
(
  input  logic [31:4] lowPart,
  input  logic        highBit,
  output idxT         homeIdx
);
  // Bytes 1..3 of the low part are bit-reversed in full; byte 0 only
  // contributes its reversed bits 3:0 to the index.
  logic [31:8] revUpper;
  logic [3:0]  revLow0;
  logic [8:0]  h1, h2, h3;

  generate
    for (genvar g = 1; g < 4; g++) begin : g_byte
      for (genvar b = 0; b < 8; b++) begin : g_bit
        assign revUpper[g*8+b] = lowPart[g*8+7-b];
      end
    end
    for (genvar b = 0; b < 4; b++) begin : g_low
      assign revLow0[b] = lowPart[7-b];
    end
  endgenerate

  assign h1 = {revUpper[14:8], revLow0[1:0]};
  assign h2 = revUpper[23:15];
  assign h3 = {highBit, revUpper[31:24]};
  assign homeIdx = {revLow0[3:2], h1 ^ h2 ^ h3};
endmodule

// File: rtl/macfilt_dp.sv
module macfilt_dp
  import macfilt_pkg::*;
#(
  parameter int HOPS = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlT               ctl,
  input  logic [ADDR_W-1:0] macAddr,
  input  logic [63:0]       memRdData,
  output idxT               memAddr,
  output stsT               sts,
  output logic              hit,
  output logic              skipFlag,
  output logic              discardFlag
);
  localparam int HOP_W = $clog2(HOPS + 1);

  logic [ADDR_W-1:0] macReg;
  idxT               probeIdx, homeIdx;
  logic [HOP_W-1:0]  hopCnt;
  entryT             rdEntry;
  keyT               key;

  macfilt_hash u_hash (
    .lowPart (macAddr[31:4]),
    .highBit (macAddr[39]),
    .homeIdx (homeIdx)
  );

  assign rdEntry = memRdData;
  assign key     = keyOf(macReg);

  assign sts.entryValid = rdEntry.lo[0];
  assign sts.keyMatch   = (rdEntry.lo[WORD_W-1:3] == key.loTag) && (rdEntry.hi == key.hi);
  assign sts.lastHop    = (hopCnt == HOP_W'(HOPS - 1));
  assign memAddr        = probeIdx;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      macReg   <= '0;
      probeIdx <= '0;
      hopCnt   <= '0;
    end else if (ctl.load) begin
      macReg   <= macAddr;
      probeIdx <= homeIdx;
      hopCnt   <= '0;
    end else if (ctl.advance) begin
      probeIdx <= probeIdx + 1'b1;
      hopCnt   <= hopCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hit         <= 1'b0;
      skipFlag    <= 1'b0;
      discardFlag <= 1'b0;
    end else if (ctl.capture) begin
      hit         <= sts.entryValid && sts.keyMatch;
      skipFlag    <= sts.entryValid && sts.keyMatch && rdEntry.lo[1];
      discardFlag <= sts.entryValid && sts.keyMatch && rdEntry.lo[2];
    end
  end
endmodule

// File: rtl/macfilt_ctrl.sv
module macfilt_ctrl
  import macfilt_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic lookupStb,
  input  stsT  sts,
  output ctlT  ctl,
  output logic memRdEn,
  output logic done
);
  stT st, stNext;

  always_comb begin
    ctl    = '0;
    stNext = st;
    case (st)
      ST_IDLE: begin
        if (lookupStb) begin
          ctl.load = 1'b1;
          stNext   = ST_READ;
        end
      end
      ST_READ: stNext = ST_EVAL;
      ST_EVAL: begin
        if (!sts.entryValid || sts.keyMatch || sts.lastHop) begin
          ctl.capture = 1'b1;
          stNext      = ST_IDLE;
        end else begin
          ctl.advance = 1'b1;
          stNext      = ST_READ;
        end
      end
      default: stNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st   <= ST_IDLE;
      done <= 1'b0;
    end else begin
      st   <= stNext;
      done <= ctl.capture;
    end
  end

  assign memRdEn = (st == ST_READ);
endmodule

// File: rtl/macfilt_top.sv
module macfilt_top
  import macfilt_pkg::*;
#(
  parameter int HOPS = 12
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        lookupStb,
  input  logic [47:0] macAddr,
  output logic        memRdEn,
  output logic [10:0] memAddr,
  input  logic [63:0] memRdData,
  output logic        done,
  output logic        hit,
  output logic        skipFlag,
  output logic        discardFlag
);
  ctlT ctl;
  stsT sts;

  macfilt_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .lookupStb (lookupStb),
    .sts       (sts),
    .ctl       (ctl),
    .memRdEn   (memRdEn),
    .done      (done)
  );

  macfilt_dp #(.HOPS(HOPS)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .ctl         (ctl),
    .macAddr     (macAddr),
    .memRdData   (memRdData),
    .memAddr     (memAddr),
    .sts         (sts),
    .hit         (hit),
    .skipFlag    (skipFlag),
    .discardFlag (discardFlag)
  );
endmodule

// File: rtl/macfilt_chk.sv
module macfilt_chk #(
  parameter int HOPS = 12
) (
  input logic        clk,
  input logic        rstN,
  input logic        memRdEn,
  input logic [10:0] memAddr,
  input logic        done,
  input logic        hit,
  input logic        skipFlag,
  input logic        discardFlag
);
  logic [7:0] readsSince;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        readsSince <= '0;
    else if (done)    readsSince <= '0;
    else if (memRdEn) readsSince <= readsSince + 1'b1;
  end

  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  a_r8_read_gap: assert property (@(posedge clk) disable iff (!rstN)
    memRdEn |=> !memRdEn);

  a_r4_next_slot: assert property (@(posedge clk) disable iff (!rstN)
    (memRdEn && $past(memRdEn, 2)) |-> (memAddr == 11'($past(memAddr, 2) + 11'd1)));

  a_r7_flags_need_hit: assert property (@(posedge clk) disable iff (!rstN)
    (skipFlag || discardFlag) |-> hit);

  a_r6_hop_budget: assert property (@(posedge clk) disable iff (!rstN)
    readsSince <= 8'(HOPS));
endmodule

bind macfilt_top macfilt_chk #(.HOPS(HOPS)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .memRdEn     (memRdEn),
  .memAddr     (memAddr),
  .done        (done),
  .hit         (hit),
  .skipFlag    (skipFlag),
  .discardFlag (discardFlag)
);

// File: tb/sim_macfilt_top.sv
`timescale 1ns/1ps
module sim_macfilt_top;
  localparam int HOPS = 12;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        lookupStb = 1'b0;
  logic [47:0] macAddr = '0;
  logic        memRdEn;
  logic [10:0] memAddr;
  logic [63:0] memRdData = '0;
  logic        done, hit, skipFlag, discardFlag;

  logic [63:0] tbl [2048];
  logic [10:0] plog [64];
  int          pcnt = 0;
  int          nChecks = 0;
  int          nFails = 0;
  bit          finished = 1'b0;

  always #4 clk = ~clk;

  macfilt_top #(.HOPS(HOPS)) u0 (
    .clk(clk), .rstN(rstN), .lookupStb(lookupStb), .macAddr(macAddr),
    .memRdEn(memRdEn), .memAddr(memAddr), .memRdData(memRdData),
    .done(done), .hit(hit), .skipFlag(skipFlag), .discardFlag(discardFlag)
  );

  always @(posedge clk) begin
    if (memRdEn) begin
      memRdData <= tbl[memAddr];
      plog[pcnt % 64] <= memAddr;
      pcnt <= pcnt + 1;
    end
  end

  function automatic logic [7:0] flipByte(input logic [7:0] x);
    logic [7:0] sw, r;
    sw = {x[3:0], x[7:4]};
    for (int n = 0; n < 2; n++)
      for (int b = 0; b < 4; b++) r[n*4+b] = sw[n*4+3-b];
    return r;
  endfunction

  function automatic logic [10:0] refHash(input logic [47:0] a);
    logic [15:0] th;
    logic [31:0] tl;
    logic [8:0]  f;
    th = {flipByte(a[47:40]), flipByte(a[39:32])};
    tl = {flipByte(a[31:24]), flipByte(a[23:16]), flipByte(a[15:8]), flipByte(a[7:0])};
    f  = {tl[14:8], tl[1:0]} ^ tl[23:15] ^ {th[0], tl[31:24]};
    return {tl[3:2], f};
  endfunction

  function automatic logic [63:0] refEntry(input logic [47:0] a, input logic sk, input logic ds);
    logic [31:0] lo, hi;
    logic [7:0]  b0, b1, b2, b3, b4, b5;
    {b0, b1, b2, b3, b4, b5} = a;
    lo = '0; hi = '0;
    lo[0] = 1'b1; lo[1] = sk; lo[2] = ds;
    lo[6:3] = b0[3:0];   lo[10:7] = b0[7:4];
    lo[14:11] = b1[3:0]; lo[18:15] = b1[7:4];
    lo[22:19] = b2[3:0]; lo[26:23] = b2[7:4];
    lo[30:27] = b3[3:0]; lo[31] = b3[4];
    hi[2:0] = b3[7:5];
    hi[6:3] = b4[3:0];   hi[10:7] = b4[7:4];
    hi[14:11] = b5[3:0]; hi[18:15] = b5[7:4];
    return {hi, lo};
  endfunction

  function automatic logic [47:0] filler(input logic [47:0] a, input int k);
    return a ^ {8'(k + 1), 40'h0};
  endfunction

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic clearTbl();
    for (int i = 0; i < 2048; i++) tbl[i] = '0;
  endtask

  task automatic findAddr(input logic [10:0] want, input logic [47:0] seed, output logic [47:0] got);
    got = seed;
    for (int k = 0; k < 65536; k++) begin
      if (refHash(seed ^ 48'(k)) == want) begin
        got = seed ^ 48'(k);
        break;
      end
    end
  endtask

  // Runs one lookup; returns result, probe count and strobe-to-done cycles.
  task automatic runLookup(input logic [47:0] a, output logic h, output logic sk,
                           output logic ds, output int probes, output int cyc);
    int base;
    @(negedge clk);
    base = pcnt;
    macAddr = a;
    lookupStb = 1'b1;
    @(posedge clk);
    @(negedge clk);
    lookupStb = 1'b0;
    cyc = 0;
    while (!done && cyc < 200) begin
      @(posedge clk);
      @(negedge clk);
      cyc++;
    end
    h = hit; sk = skipFlag; ds = discardFlag;
    probes = pcnt - base;
    @(negedge clk);
    check(done == 1'b0, "R8 done single pulse", longint'(done), 0);
  endtask

  task automatic t_reset();
    check(done == 0, "R1 done after reset", longint'(done), 0);
    check(hit == 0 && skipFlag == 0 && discardFlag == 0, "R1 result after reset",
          longint'({hit, skipFlag, discardFlag}), 0);
    check(memRdEn == 0, "R1 no read after reset", longint'(memRdEn), 0);
  endtask

  task automatic t_empty();
    logic h, sk, ds; int p, c; logic [47:0] a;
    a = 48'h00A0_C914_5E37;
    clearTbl();
    runLookup(a, h, sk, ds, p, c);
    check(h == 0, "R5 empty table miss", longint'(h), 0);
    check(p == 1, "R5 one probe on empty slot", p, 1);
    check(plog[(pcnt - 1) % 64] == refHash(a), "R2 home index", plog[(pcnt - 1) % 64], refHash(a));
    check(c == 2, "R8 latency one probe", c, 2);
  endtask

  task automatic t_home_hit();
    logic h, sk, ds; int p, c; logic [47:0] a, b;
    a = 48'h3C5A_0F81_7E24;
    b = 48'hF1E2_D3C4_B5A6;
    clearTbl();
    tbl[refHash(a)] = refEntry(a, 1'b1, 1'b0);
    runLookup(a, h, sk, ds, p, c);
    check(h == 1 && p == 1, "R3 hit in home slot", longint'({h, 8'(p)}), 64'h101);
    check(sk == 1 && ds == 0, "R7 skip flag returned", longint'({sk, ds}), 2);
    check(plog[(pcnt - 1) % 64] == refHash(a), "R2 home index second pattern",
          plog[(pcnt - 1) % 64], refHash(a));
    clearTbl();
    tbl[refHash(b)] = refEntry(b, 1'b0, 1'b1);
    runLookup(b, h, sk, ds, p, c);
    check(h == 1 && sk == 0 && ds == 1, "R7 discard flag returned",
          longint'({h, sk, ds}), 5);
  endtask

  task automatic t_chain();
    logic h, sk, ds; int p, c; logic [47:0] a; logic [10:0] hx;
    a = 48'h0255_6677_8899;
    hx = refHash(a);
    clearTbl();
    tbl[hx] = refEntry(filler(a, 0), 0, 0);
    tbl[11'(hx + 1)] = refEntry(filler(a, 1), 0, 0);
    tbl[11'(hx + 2)] = refEntry(a, 0, 0);
    runLookup(a, h, sk, ds, p, c);
    check(h == 1 && p == 3, "R4 hit after two collisions", longint'({h, 8'(p)}), 64'h103);
    check(plog[(pcnt - 2) % 64] == 11'(hx + 1) && plog[(pcnt - 1) % 64] == 11'(hx + 2),
          "R4 consecutive slots", plog[(pcnt - 1) % 64], 11'(hx + 2));
    check(c == 6, "R8 latency three probes", c, 6);
    check(sk == 0 && ds == 0, "R7 clear flags on hit", longint'({sk, ds}), 0);
  endtask

  task automatic t_wrap();
    logic h, sk, ds; int p, c; logic [47:0] a;
    findAddr(11'd2047, 48'h1234_5678_0000, a);
    check(refHash(a) == 11'd2047, "R4 wrap address found", refHash(a), 2047);
    clearTbl();
    tbl[2047] = refEntry(filler(a, 2), 0, 0);
    tbl[0] = refEntry(a, 1, 1);
    runLookup(a, h, sk, ds, p, c);
    check(h == 1 && p == 2, "R4 wrap to slot 0 hit", longint'({h, 8'(p)}), 64'h102);
    check(plog[(pcnt - 1) % 64] == 11'd0, "R4 second read at slot 0", plog[(pcnt - 1) % 64], 0);
  endtask

  task automatic t_hoplimit();
    logic h, sk, ds; int p, c; logic [47:0] a; logic [10:0] hx;
    a = 48'hAA11_BB22_CC33;
    hx = refHash(a);
    clearTbl();
    for (int i = 0; i < HOPS; i++) tbl[11'(hx + 11'(i))] = refEntry(filler(a, i), 0, 0);
    tbl[11'(hx + 11'(HOPS))] = refEntry(a, 0, 0);
    runLookup(a, h, sk, ds, p, c);
    check(h == 0, "R6 miss at hop budget", longint'(h), 0);
    check(p == HOPS, "R6 read count at budget", p, HOPS);
    check(c == 2 * HOPS, "R8 latency at budget", c, 2 * HOPS);
    tbl[11'(hx + 11'(HOPS - 1))] = refEntry(a, 0, 0);
    runLookup(a, h, sk, ds, p, c);
    check(h == 1 && p == HOPS, "R6 hit on last allowed hop", longint'({h, 8'(p)}), 64'h100 + HOPS);
  endtask

  task automatic t_near();
    logic h, sk, ds; int p, c; logic [47:0] a; logic [10:0] hx;
    a = 48'h5D00_4E21_9C6B;
    hx = refHash(a);
    clearTbl();
    tbl[hx] = refEntry(a ^ 48'h0000_0020_0000, 0, 0);
    runLookup(a, h, sk, ds, p, c);
    check(h == 0 && p == 2, "R3 high word bit differs", longint'({h, 8'(p)}), 2);
    tbl[hx] = refEntry(a ^ 48'h0100_0000_0000, 0, 0);
    runLookup(a, h, sk, ds, p, c);
    check(h == 0 && p == 2, "R3 low word bit differs", longint'({h, 8'(p)}), 2);
    tbl[hx] = refEntry(a, 1, 1);
    runLookup(a, h, sk, ds, p, c);
    check(h == 1 && sk == 1 && ds == 1 && p == 1, "R3 flag bits excluded from compare",
          longint'({h, sk, ds}), 7);
  endtask

  task automatic t_busy();
    int base, dones;
    logic [47:0] a, b;
    logic [10:0] hx;
    a = 48'h0255_6677_8899;
    b = 48'h6E6E_1010_2020;
    hx = refHash(a);
    clearTbl();
    tbl[hx] = refEntry(filler(a, 0), 0, 0);
    tbl[11'(hx + 1)] = refEntry(filler(a, 1), 0, 0);
    tbl[11'(hx + 2)] = refEntry(a, 1, 0);
    tbl[refHash(b)] = refEntry(b, 0, 1);
    @(negedge clk);
    base = pcnt;
    macAddr = a; lookupStb = 1'b1;
    @(negedge clk);
    lookupStb = 1'b0;
    @(negedge clk);
    macAddr = b; lookupStb = 1'b1;
    @(negedge clk);
    lookupStb = 1'b0;
    dones = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (done) begin
        dones++;
        check(hit == 1 && skipFlag == 1 && discardFlag == 0, "R9 result of first lookup",
              longint'({hit, skipFlag, discardFlag}), 6);
      end
    end
    check(dones == 1, "R9 single done", dones, 1);
    check(pcnt - base == 3, "R9 no extra reads", pcnt - base, 3);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    t_reset();
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_empty();
    t_home_hit();
    t_chain();
    t_wrap();
    t_hoplimit();
    t_near();
    t_busy();
    finished = 1'b1;
  end

  initial begin
    fork
      begin wait (finished); end
      begin
        repeat (100000) @(posedge clk);
        nChecks++;
        nFails++;
        $display("FAIL watchdog actual=running expected=finished");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule